// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. It works out whether an embedded program or erase operation has finished. After a requester pulses `start` with a status address, the block issues back-to-back reads of the status byte at that address. It compares the toggle bit of each pair of reads. A toggle bit that is the same in both reads means the operation is complete. A toggle bit that changes means the operation is still running, and polling continues. When the toggle bit changes and the exceeded-time flag is set in the second read, the block cannot decide from that one comparison. The toggle bit may have stopped in the same moment the flag rose, so the block reads one more pair before it decides.

On a failed operation, the block writes the reset command to the device so that the device returns to array reads. It then reports the failure. A poll-count limit ends an operation that never raises the exceeded-time flag. That case is reported as a failure with a timeout indication, and the reset command is also written. The requester can abandon polling with `abort`. A later `start` always begins again from the first pair, with the full poll budget.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: On `start` while idle, the block latches `poll_addr`. Every read of the operation goes to that address. A `start` while busy has no effect.
- R2: Each status check is a pair of reads issued one after the other. If bit TOG_BIT (default 6) has the same value in both reads, the block reports pass and issues no write.
- R3: If bit TOG_BIT differs between the two reads of a pair and bit TMO_BIT (default 5) of the second read is 0, the block issues a new pair of reads.
- R4: If bit TOG_BIT differs and bit TMO_BIT of the second read is 1, the block issues exactly one recheck pair. If TOG_BIT is equal in the recheck pair, the block reports pass with no write.
- R5: If TOG_BIT still differs in the recheck pair, the block writes RESET_CMD (default 8'hF0) to the latched address, then reports fail with timeout low.
- R6: If MAX_POLLS pairs in a row show toggling with TMO_BIT low, the block writes RESET_CMD and reports fail with `timeout` high.
- R7: `done` is a one-cycle pulse. `pass` and `fail` are valid with it, are never both high, and hold until the next accepted `start`. After reset, `busy`, `done`, `pass`, `fail`, `timeout` and `bus_req` are all low.
- R8: `abort` during the read phase returns the block to idle in the next cycle, with `bus_req` low and no `done`. The next `start` begins from the first pair with the full MAX_POLLS budget.
- R9: Once `bus_req` is raised, it stays high with a stable address and direction until `bus_ack`, unless `abort` is applied. A write occurs only with data RESET_CMD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted when idle) |
| abort | input | 1 | Abandon polling during the read phase |
| poll_addr | input | AW | Status address to poll |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed; reset command written |
| timeout | output | 1 | Failure caused by the poll-count limit |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write (reset command), 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer accepted and completed |

## Verification
The checker watches the cycle-level rules on every cycle:
- the single-cycle `done` pulse and the exclusive pass/fail outcome;
- a fail always directly preceded by an acknowledged reset-command write, and a pass by an acknowledged read;
- a bus request held steady until it is acknowledged.

Whether the outcome is correct for a given sequence of device status bytes depends on the whole history of reads. Only the bench's scenarios can show this. The bench sweeps every point at which the device stops toggling against every point at which the exceeded-time flag rises, including the never case. It also covers abort-and-restart.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MAX_POLLS = 1000,
  parameter logic [7:0] RESET_CMD = 8'hF0,
  parameter int TOG_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] poll_addr,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] LAST = PW'(MAX_POLLS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_RC1, S_RC2, S_RST} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic          first_q;
  logic [PW-1:0] polls_q;

  wire reading = (st == S_RD1) || (st == S_RD2) || (st == S_RC1) || (st == S_RC2);
  wire tog     = bus_rdata[TOG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      first_q <= 1'b0;
      polls_q <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort && reading) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            addr_q  <= poll_addr;
            polls_q <= '0;
            pass    <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
            st      <= S_RD1;
          end
          S_RD1, S_RC1: if (bus_ack) begin
            first_q <= tog;
            st      <= (st == S_RD1) ? S_RD2 : S_RC2;
          end
          S_RD2: if (bus_ack) begin
            if (tog == first_q) begin
              done <= 1'b1;
              pass <= 1'b1;
              st   <= S_IDLE;
            end else if (bus_rdata[TMO_BIT]) begin
              st <= S_RC1;
            end else if (polls_q == LAST) begin
              timeout <= 1'b1;
              st      <= S_RST;
            end else begin
              polls_q <= polls_q + 1'b1;
              st      <= S_RD1;
            end
          end
          S_RC2: if (bus_ack) begin
            if (tog == first_q) begin
              done <= 1'b1;
              pass <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_RST;
            end
          end
          S_RST: if (bus_ack) begin
            done <= 1'b1;
            fail <= 1'b1;
            st   <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign bus_req   = busy;
  assign bus_we    = (st == S_RST);
  assign bus_addr  = addr_q;
  assign bus_wdata = bus_we ? DW'(RESET_CMD) : '0;
endmodule

// File: rtl/toggle_poll_ctrl_chk.sv
module toggle_poll_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [7:0] RESET_CMD = 8'hF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          timeout,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pass && fail));
  // R7
  done_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass ^ fail));
  // R6
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout && done |-> fail);
  // R5
  fail_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> $past(bus_req && bus_we && bus_ack));
  // R2
  pass_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> $past(bus_req && !bus_we && bus_ack));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !abort |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  // R9
  write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata == DW'(RESET_CMD));
endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk #(.AW(AW), .DW(DW), .RESET_CMD(RESET_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .done(done), .pass(pass), .fail(fail),
  .timeout(timeout), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MAXP = 4;

  logic clk = 0, rst_n = 0, start = 0, abort = 0;
  logic [AW-1:0] poll_addr = '0;
  logic busy, done, pass, fail, timeout, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_ack;

  int tests = 0, fails = 0;
  int cfg_b = 0, cfg_f = 0;
  logic clr = 0;
  logic [AW-1:0] exp_addr = '0;
  int rd_cnt, wr_cnt, addr_bad;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] wr_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .poll_addr(poll_addr),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .timeout(timeout),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  function automatic logic [7:0] dev_val(int i, int b, int f);
    logic [7:0] v = 8'h00;
    v[6] = (i < b) ? 1'(i % 2) : 1'(b % 2);
    v[5] = (i >= f);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      bus_ack <= 0; bus_rdata <= 0; rd_cnt <= 0; wr_cnt <= 0; addr_bad <= 0;
      wr_data <= 0; wr_addr <= 0;
    end else begin
      bus_ack <= 0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1;
        if (bus_addr != exp_addr) addr_bad <= addr_bad + 1;
        if (bus_we) begin
          wr_cnt <= wr_cnt + 1; wr_data <= bus_wdata; wr_addr <= bus_addr;
        end else begin
          bus_rdata <= dev_val(rd_cnt, cfg_b, cfg_f);
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_outcome(input int b, input int f, output bit ep, output bit etmo,
                                output int ereads);
    int r = 0;
    ep = 0; etmo = 0;
    for (int p = 0; p < MAXP; p++) begin
      bit x = dev_val(r, b, f)[6], y = dev_val(r + 1, b, f)[6];
      bit d5 = dev_val(r + 1, b, f)[5];
      r += 2;
      if (x == y) begin ep = 1; ereads = r; return; end
      if (d5) begin
        x = dev_val(r, b, f)[6]; y = dev_val(r + 1, b, f)[6];
        r += 2;
        ep = (x == y); ereads = r; return;
      end
    end
    etmo = 1; ereads = r;
  endtask

  task automatic clear_model();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) begin seen = 1; return; end
    end
  endtask

  task automatic run(input int b, input int f);
    bit ep, etmo, seen;
    int er;
    cfg_b = b; cfg_f = f;
    clear_model();
    exp_addr = AW'(b * 16 + f + 1);
    poll_addr = exp_addr; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    poll_addr = ~exp_addr; start = 1;  // R1: ignored while busy
    @(negedge clk); start = 0;
    expect_outcome(b, f, ep, etmo, er);
    wait_done(seen);
    chk(seen, "R7 done", int'(seen), 1);
    chk(pass == ep && fail == !ep, ep ? "R2/R4 pass" : "R5/R6 fail", int'(pass), int'(ep));
    chk(timeout == etmo, "R6 timeout", int'(timeout), int'(etmo));
    chk(rd_cnt == er, "R3 read count", rd_cnt, er);
    chk(wr_cnt == (ep ? 0 : 1), "R5 reset write count", wr_cnt, ep ? 0 : 1);
    if (!ep) chk(wr_data == 8'hF0 && wr_addr == exp_addr, "R5 reset write data", int'(wr_data), 8'hF0);
    chk(addr_bad == 0, "R1 read address", addr_bad, 0);
    @(negedge clk);
    chk(!done && pass == ep && fail == !ep, "R7 done width / hold", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !pass && !fail && !timeout && !bus_req, "R7 reset state", int'(busy), 0);

    for (int b = 0; b <= 12; b++)
      for (int f = 0; f <= 13; f++)
        run(b, (f == 13) ? 999 : f);

    // R8: abort mid-poll, then restart with full budget
    cfg_b = 999; cfg_f = 999;
    clear_model();
    exp_addr = 8'h5A; poll_addr = exp_addr; start = 1;
    @(negedge clk); start = 0;
    repeat (9) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk(!bus_req && !busy, "R8 abort idle", int'(bus_req), 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (done) seen = 1; end
    chk(!seen, "R8 no done after abort", int'(seen), 0);
    clear_model();
    start = 1; @(negedge clk); start = 0;
    wait_done(seen);
    chk(seen && fail && timeout, "R8 restart outcome", int'(fail), 1);
    chk(rd_cnt == 2 * MAXP, "R8 restart full budget", rd_cnt, 2 * MAXP);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule